// File: doc/BRIEF.md
# Event Performance Monitor

This block is a bank of programmable event counters next to one dedicated cycle counter. All of them are reached through a single-cycle register port. Each general counter carries a type code. The type code picks which of the plain event input pulses it counts, or marks the counter as driven by software writes. The cycle counter is fixed at index 31. It counts clock cycles, either one per clock or one per 64 clocks when the prescaler is on.

A control word holds the global run bit and the prescale bit, plus a few stored configuration bits. It also carries two one-shot actions that zero either the general counters or the cycle counter. Count enables, interrupt enables and overflow flags are 32-bit masks. Each has a set view and a clear view, with bit i for general counter i and bit 31 for the cycle counter. A counter raises its overflow flag when it wraps from all ones to zero. The level interrupt is high whenever a flag is up and also enabled.

Register addresses on `reg_addr`: 0 control, 1/2 count-enable set/clear, 3/4 interrupt-enable set/clear, 5/6 overflow set/clear, 7 software increment, 8 selection, 9 selected type, 10 selected value, 11/12 cycle counter low/high word. Reads are combinational. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `evmon_unit`

## Requirements
- R1: After reset every counter, type, mask and flag is zero and `irq` is low. The control word (address 0) reads only its constant fields.
- R2: A control write stores only the bits of mask 0x39: bit 0 run, bit 3 prescale, bits 4 and 5. Bits 1 and 2 read as zero. Bits 15:11 read NUM_CTR, bits 23:16 ID_CODE, bits 31:24 IMPL_CODE, and bit 6 reads LONG_CYC.
- R3: A general counter whose type is k (1..NUM_EVT) adds one in each cycle where `evt_in[k-1]` is high, but only when the control run bit and its own count-enable bit are both 1. Otherwise it holds.
- R4: Writing control with bit 1 set zeroes every general counter and leaves the cycle counter unchanged.
- R5: With run and count-enable bit 31 set and the prescale bit clear, the cycle counter (addresses 11/12, or selected value with selection 31) adds one per clock.
- R6: With the prescale bit set, the cycle counter adds one once every 64 counting clocks. A 6-bit remainder keeps the partial progress.
- R7: Writing control with bit 2 set zeroes the cycle counter and its prescale remainder.
- R8: A counter that wraps from all ones to zero sets its overflow flag (bit i, or bit 31 for the cycle counter). Address 5 sets flags and address 6 clears the flags written as 1.
- R9: `irq` is high exactly when some overflow flag and the same interrupt-enable bit are both 1.
- R10: Writing 1 to bit i of address 7 adds one to counter i only if its type is 0x00 and it is counting. Counters of other types ignore it.
- R11: With a selection (address 8, 5 bits) of a counter index that does not exist (NUM_CTR..30), the selected type and value read zero and writes there are ignored. Mask bits of such indices read zero.
- R12: Selection 31 makes address 9 access an 8-bit cycle filter register that stores and reads back its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NUM_EVT | Event pulse lines, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest case to reach is the prescale remainder: its state is invisible at the ports and only shows as the timing of the next cycle-counter step. The bench leaves the remainder at a known nonzero position by counting an exact number of clocks. It then issues the cycle reset and stops the counter before 64 more clocks have passed. A stale remainder would then produce a step that a cleared one cannot. Overflow is reached by preloading counters a step or two below the wrap point through the value registers.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CYC_IDX = 31;
  localparam int SEL_W   = 5;

  // register addresses
  localparam logic [3:0] RA_CTRL     = 4'd0;
  localparam logic [3:0] RA_CEN_SET  = 4'd1;
  localparam logic [3:0] RA_CEN_CLR  = 4'd2;
  localparam logic [3:0] RA_IEN_SET  = 4'd3;
  localparam logic [3:0] RA_IEN_CLR  = 4'd4;
  localparam logic [3:0] RA_OVF_SET  = 4'd5;
  localparam logic [3:0] RA_OVF_CLR  = 4'd6;
  localparam logic [3:0] RA_SWINC    = 4'd7;
  localparam logic [3:0] RA_SEL      = 4'd8;
  localparam logic [3:0] RA_SEL_TYPE = 4'd9;
  localparam logic [3:0] RA_SEL_VAL  = 4'd10;
  localparam logic [3:0] RA_CYC_LO   = 4'd11;
  localparam logic [3:0] RA_CYC_HI   = 4'd12;

  // control word bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_EVRST = 1;
  localparam int CB_CYRST = 2;
  localparam int CB_DIV   = 3;
  localparam int CB_LONG  = 6;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_0039;
endpackage

// File: rtl/evmon_evctr.sv
module evmon_evctr #(
  parameter int NUM_EVT = 8,
  parameter int TYPE_W  = 8,
  parameter int CTR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              sw_pulse,
  input  logic              clr,
  input  logic              wr_type,
  input  logic              wr_val,
  input  logic [CTR_W-1:0]  wdata,
  output logic [TYPE_W-1:0] type_q,
  output logic [CTR_W-1:0]  cnt_q,
  output logic              ovf_pulse
);
  function automatic logic [CTR_W:0] bump(input logic [CTR_W-1:0] v);
    return {1'b0, v} + {{CTR_W{1'b0}}, 1'b1};
  endfunction

  logic            evt_sel;
  logic            hit;
  logic [CTR_W:0]  sum;

  always_comb begin
    evt_sel = 1'b0;
    if (type_q == '0) evt_sel = sw_pulse;
    else begin
      for (int k = 0; k < NUM_EVT; k++)
        if (type_q == TYPE_W'(k + 1)) evt_sel = evt_in[k];
    end
  end

  assign hit       = run && evt_sel;
  assign sum       = bump(cnt_q);
  assign ovf_pulse = hit && !clr && !wr_val && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_type) type_q <= wdata[TYPE_W-1:0];
      if (clr)         cnt_q <= '0;
      else if (wr_val) cnt_q <= wdata;
      else if (hit)    cnt_q <= sum[CTR_W-1:0];
    end
  end

  a_r4_evclr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> (cnt_q == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr_val) |=> $stable(cnt_q));
endmodule

// File: rtl/evmon_cyc.sv
module evmon_cyc #(
  parameter int PRE_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        div,
  input  logic        long_mode,
  input  logic        clr,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt_q,
  output logic        ovf_pulse
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  function automatic logic [64:0] step(input logic [63:0] v, input logic lng);
    logic [32:0] lo;
    if (lng) return {1'b0, v} + 65'd1;
    lo = {1'b0, v[31:0]} + 33'd1;
    return {lo[32], 32'd0, lo[31:0]};
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [64:0]      nxt;

  assign tick      = run && (!div || pre_q == PRE_LAST);
  assign nxt       = step(cnt_q, long_mode);
  assign ovf_pulse = tick && !clr && !wr_lo && !wr_hi && nxt[64];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr)             pre_q <= '0;
      else if (run && div) pre_q <= pre_q + 1'b1;
      if (clr) cnt_q <= '0;
      else if (wr_lo || wr_hi) begin
        if (wr_lo) cnt_q[31:0]  <= wdata;
        if (wr_hi) cnt_q[63:32] <= wdata;
      end else if (tick) cnt_q <= nxt[63:0];
    end
  end

  a_r7_cyclr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == 64'd0 && pre_q == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div && pre_q != PRE_LAST && !clr && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div && !clr && !wr_lo && !wr_hi && !long_mode)
      |=> (cnt_q[31:0] == $past(cnt_q[31:0]) + 32'd1));
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
  import evmon_pkg::*;
#(
  parameter int          NUM_CTR   = 4,
  parameter int          NUM_EVT   = 8,
  parameter int          TYPE_W    = 8,
  parameter logic [7:0]  ID_CODE   = 8'h3C,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter bit          LONG_CYC  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam logic [31:0] VALID = (32'd1 << CYC_IDX) | ((32'd1 << NUM_CTR) - 32'd1);

  logic [31:0]      ctrl_q, cen_q, ien_q, ovf_q, ovf_d, hw_ovf;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       cflt_q;
  logic [31:0]      cnt_arr [NUM_CTR];
  logic [TYPE_W-1:0] typ_arr [NUM_CTR];
  logic [NUM_CTR-1:0] ev_ovf;
  logic [63:0]      cyc_cnt;
  logic             cyc_ovf;
  logic             sel_cyc;

  function automatic logic wr_at(input logic w, input logic [3:0] a, input logic [3:0] t);
    return w && (a == t);
  endfunction

  logic ev_clr, cy_clr;
  assign ev_clr  = wr_at(reg_wr, reg_addr, RA_CTRL) && reg_wdata[CB_EVRST];
  assign cy_clr  = wr_at(reg_wr, reg_addr, RA_CTRL) && reg_wdata[CB_CYRST];
  assign sel_cyc = (sel_q == SEL_W'(CYC_IDX));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evmon_evctr #(.NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W), .CTR_W(32)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[CB_RUN] && cen_q[i]),
      .evt_in   (evt_in),
      .sw_pulse (wr_at(reg_wr, reg_addr, RA_SWINC) && reg_wdata[i]),
      .clr      (ev_clr),
      .wr_type  (wr_at(reg_wr, reg_addr, RA_SEL_TYPE) && sel_q == SEL_W'(i)),
      .wr_val   (wr_at(reg_wr, reg_addr, RA_SEL_VAL) && sel_q == SEL_W'(i)),
      .wdata    (reg_wdata),
      .type_q   (typ_arr[i]),
      .cnt_q    (cnt_arr[i]),
      .ovf_pulse(ev_ovf[i])
    );
  end

  evmon_cyc #(.PRE_W(6)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[CB_RUN] && cen_q[CYC_IDX]),
    .div      (ctrl_q[CB_DIV]),
    .long_mode(LONG_CYC),
    .clr      (cy_clr),
    .wr_lo    (wr_at(reg_wr, reg_addr, RA_CYC_LO) ||
               (wr_at(reg_wr, reg_addr, RA_SEL_VAL) && sel_cyc)),
    .wr_hi    (wr_at(reg_wr, reg_addr, RA_CYC_HI)),
    .wdata    (reg_wdata),
    .cnt_q    (cyc_cnt),
    .ovf_pulse(cyc_ovf)
  );

  always_comb begin
    hw_ovf = '0;
    for (int i = 0; i < NUM_CTR; i++) hw_ovf[i] = ev_ovf[i];
    hw_ovf[CYC_IDX] = cyc_ovf;
    ovf_d = ovf_q;
    if (wr_at(reg_wr, reg_addr, RA_OVF_SET)) ovf_d = ovf_d | (reg_wdata & VALID);
    if (wr_at(reg_wr, reg_addr, RA_OVF_CLR)) ovf_d = ovf_d & ~reg_wdata;
    ovf_d = ovf_d | hw_ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cen_q  <= '0;
      ien_q  <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
      cflt_q <= '0;
    end else begin
      ovf_q <= ovf_d;
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL:     ctrl_q <= reg_wdata & CTRL_KEEP;
          RA_CEN_SET:  cen_q  <= cen_q | (reg_wdata & VALID);
          RA_CEN_CLR:  cen_q  <= cen_q & ~reg_wdata;
          RA_IEN_SET:  ien_q  <= ien_q | (reg_wdata & VALID);
          RA_IEN_CLR:  ien_q  <= ien_q & ~reg_wdata;
          RA_SEL:      sel_q  <= reg_wdata[SEL_W-1:0];
          RA_SEL_TYPE: if (sel_cyc) cflt_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata          = ctrl_q;
        reg_rdata[CB_LONG] = LONG_CYC;
        reg_rdata[15:11]   = 5'(NUM_CTR);
        reg_rdata[23:16]   = ID_CODE;
        reg_rdata[31:24]   = IMPL_CODE;
      end
      RA_CEN_SET, RA_CEN_CLR: reg_rdata = cen_q;
      RA_IEN_SET, RA_IEN_CLR: reg_rdata = ien_q;
      RA_OVF_SET, RA_OVF_CLR: reg_rdata = ovf_q;
      RA_SEL:      reg_rdata = 32'(sel_q);
      RA_SEL_TYPE: begin
        if (sel_cyc) reg_rdata = 32'(cflt_q);
        for (int i = 0; i < NUM_CTR; i++)
          if (sel_q == SEL_W'(i)) reg_rdata = 32'(typ_arr[i]);
      end
      RA_SEL_VAL: begin
        if (sel_cyc) reg_rdata = cyc_cnt[31:0];
        for (int i = 0; i < NUM_CTR; i++)
          if (sel_q == SEL_W'(i)) reg_rdata = cnt_arr[i];
      end
      RA_CYC_LO: reg_rdata = cyc_cnt[31:0];
      RA_CYC_HI: reg_rdata = cyc_cnt[63:32];
      default: ;
    endcase
  end

  assign irq = |(ovf_q & ien_q);

  a_r2_actbits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_CTRL) |-> (reg_rdata[CB_CYRST:CB_EVRST] == 2'b00));
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_OVF_CLR && reg_wdata == 32'hFFFF_FFFF && hw_ovf == '0) |=> !irq);
  a_r11_void_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_SEL_VAL && sel_q >= SEL_W'(NUM_CTR) && !sel_cyc) |-> (reg_rdata == '0));
  a_r4_cyc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !cy_clr && !(ctrl_q[CB_RUN] && cen_q[CYC_IDX]) && !reg_wdata[CB_RUN])
      |=> $stable(cyc_cnt));
endmodule

// File: tb/evmon_unit_tb.sv
module evmon_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evmon_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string req);
    #1;
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  task automatic pulse(input int line, input int n);
    repeat (n) begin
      evt_in[line] = 1'b1;
      @(negedge clk);
      evt_in[line] = 1'b0;
    end
  endtask

  task automatic t_reset();
    expect_rd(4'd0, 32'h413C_2000, "R1");
    expect_rd(4'd11, 32'h0, "R1");
    expect_rd(4'd5, 32'h0, "R1");
    expect_irq(1'b0, "R1");
  endtask

  task automatic t_ctrl();
    wr(4'd0, 32'h0000_00F6);
    expect_rd(4'd0, 32'h413C_2030, "R2");
    wr(4'd0, 32'h0);
    expect_rd(4'd0, 32'h413C_2000, "R2");
  endtask

  task automatic t_cycle();
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h1);
    idle(9);
    wr(4'd0, 32'h0);
    expect_rd(4'd11, 32'd10, "R5");
    wr(4'd8, 32'd31);
    expect_rd(4'd10, 32'd10, "R5");
  endtask

  task automatic t_div();
    wr(4'd0, 32'h0000_000D);   // cycle reset, run, prescale
    idle(127);
    wr(4'd0, 32'h8);
    expect_rd(4'd11, 32'd2, "R6");
    wr(4'd0, 32'h9);
    idle(39);
    wr(4'd0, 32'h8);           // 40 counting clocks, remainder now 40
    expect_rd(4'd11, 32'd2, "R6");
    wr(4'd0, 32'h0000_000D);
    idle(29);
    wr(4'd0, 32'h8);           // 30 clocks after clearing: no step expected
    expect_rd(4'd11, 32'd0, "R7");
    wr(4'd0, 32'h0);
  endtask

  task automatic t_events();
    wr(4'd8, 32'd0);
    wr(4'd9, 32'd2);           // counter 0 follows evt_in[1]
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h1);
    pulse(1, 5);
    pulse(0, 3);
    expect_rd(4'd10, 32'd5, "R3");
    wr(4'd2, 32'h1);
    pulse(1, 3);
    expect_rd(4'd10, 32'd5, "R3");
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h0);
    pulse(1, 2);
    expect_rd(4'd10, 32'd5, "R3");
  endtask

  task automatic t_overflow();
    wr(4'd8, 32'd1);
    wr(4'd9, 32'd1);
    wr(4'd10, 32'hFFFF_FFFE);
    wr(4'd1, 32'h2);
    wr(4'd3, 32'h2);
    wr(4'd0, 32'h1);
    pulse(0, 1);
    expect_irq(1'b0, "R9");
    pulse(0, 1);
    expect_rd(4'd10, 32'd0, "R8");
    expect_rd(4'd5, 32'h2, "R8");
    expect_irq(1'b1, "R9");
    wr(4'd6, 32'h2);
    expect_rd(4'd6, 32'h0, "R8");
    expect_irq(1'b0, "R9");
    wr(4'd5, 32'h2);
    expect_irq(1'b1, "R9");
    wr(4'd4, 32'h2);
    expect_irq(1'b0, "R9");
    expect_rd(4'd5, 32'h2, "R8");
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0);
    // cycle counter wrap (counter 31)
    wr(4'd11, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    idle(1);
    wr(4'd0, 32'h0);
    expect_rd(4'd11, 32'd0, "R8");
    expect_rd(4'd5, 32'h8000_0000, "R8");
    wr(4'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_swinc();
    wr(4'd8, 32'd2);
    wr(4'd9, 32'd0);
    wr(4'd1, 32'h4);
    wr(4'd0, 32'h1);
    wr(4'd7, 32'h5);
    wr(4'd7, 32'h4);
    wr(4'd7, 32'h4);
    expect_rd(4'd10, 32'd3, "R10");
    wr(4'd8, 32'd0);
    expect_rd(4'd10, 32'd5, "R10");
    wr(4'd0, 32'h0);
    wr(4'd8, 32'd2);
    wr(4'd7, 32'h4);
    expect_rd(4'd10, 32'd3, "R10");
  endtask

  task automatic t_evreset();
    wr(4'd11, 32'd77);
    wr(4'd0, 32'h2);
    wr(4'd8, 32'd0);
    expect_rd(4'd10, 32'd0, "R4");
    wr(4'd8, 32'd2);
    expect_rd(4'd10, 32'd0, "R4");
    expect_rd(4'd11, 32'd77, "R4");
  endtask

  task automatic t_invalid();
    wr(4'd8, 32'd5);
    wr(4'd10, 32'h1234);
    wr(4'd9, 32'h7);
    expect_rd(4'd10, 32'd0, "R11");
    expect_rd(4'd9, 32'd0, "R11");
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0000_0400);
    expect_rd(4'd1, 32'd0, "R11");
    wr(4'd8, 32'd31);
    wr(4'd9, 32'hA5);
    expect_rd(4'd9, 32'hA5, "R12");
    wr(4'd8, 32'd3);
    expect_rd(4'd9, 32'd0, "R12");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ctrl();
    t_cycle();
    t_div();
    t_events();
    t_overflow();
    t_swinc();
    t_evreset();
    t_invalid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule